// File: doc/BRIEF.md
# Signed Integer Divider, 32 by 16

This block divides a signed 32-bit dividend by a signed 16-bit divisor. Both operands are two's-complement. It returns a 32-bit quotient and a remainder. The remainder is worked out at 16 bits and then sign-extended to a 32-bit output.

A caller holds both operands on the input pins and raises `start` for one cycle while `busy` is low. The block registers the operands and runs a radix-128 restoring datapath. This datapath produces seven quotient bits per clock. Six clock edges after the start is taken, the result registers update and `done` pulses for one cycle.

The outputs keep their values until the next result arrives. A zero divisor does not stall the block or take a different path. It sets a flag and substitutes fixed results, with the same timing as any other division.

Top module: `hdiv_signed`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to its idle state: `busy`=0, `done`=0, `quotient`=0, `remainder`=0 and `div_zero`=0.
- R2: A `start` sampled high at edge n while `busy` is low is accepted. `busy` is high after edges n through n+5. After edge n+6, `done` is 1 for exactly one cycle, `busy` is 0 and the new results are on the outputs.
- R3: For a nonzero divisor, `quotient` is the signed quotient rounded toward zero, in 32-bit two's-complement.
- R4: For a nonzero divisor, `remainder` equals dividend − quotient × divisor. It has the sign of the dividend (or is zero), its magnitude is below the divisor's, and bits 31..16 repeat bit 15.
- R5: A divisor of 0 gives `div_zero`=1, `quotient`=32'hFFFFFFFF and `remainder` equal to the dividend. The result arrives with the same six-edge timing as in R2.
- R6: A `start` that arrives while `busy` is high has no effect. The operation in flight finishes on its own schedule with its own operands, and no extra `done` follows.
- R7: A dividend of 32'h80000000 divided by a divisor of 16'hFFFF gives `quotient`=32'h80000000, `remainder`=0 and `div_zero`=0.
- R8: Between `done` pulses, `quotient`, `remainder` and `div_zero` hold their values whatever the operand pins do. `div_zero` returns to 0 when the next division by a nonzero divisor completes.
- R9: A `start` raised in the same cycle that `done` is high is accepted. Its result follows six edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division with the operands on the pins |
| dividend | input | 32 | Signed dividend |
| divisor | input | 16 | Signed divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results update |
| quotient | output | 32 | Signed quotient |
| remainder | output | 32 | Signed remainder, sign-extended from 16 bits |
| div_zero | output | 1 | Last result came from a zero divisor |

## Verification
Two events can fall in the same cycle: a result completing with its `done` pulse, and a new start being accepted. The bench provokes this by raising `start` with fresh operands in the very cycle it sees `done` high. It judges the outcome on three counts: the first result must be intact at that pulse, the second result must arrive exactly six edges later, and the second result must match its own operands. A related clash is a start that lands in the middle of a busy period. It must leave both the timing and the result of the running division untouched, and it must produce no extra `done` afterwards.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

    localparam int DD_W        = 32;
    localparam int DV_W        = 16;
    localparam int LAT_DEFAULT = 6;

    // operand context kept for the whole operation
    typedef struct packed {
        logic [DD_W-1:0] dd;
        logic            neg_dd;
        logic            neg_q;
        logic            dv_zero;
    } op_t;

    function automatic logic [DD_W-1:0] mag_dd(input logic [DD_W-1:0] v);
        return v[DD_W-1] ? (~v + 1'b1) : v;
    endfunction

    function automatic logic [DV_W-1:0] mag_dv(input logic [DV_W-1:0] v);
        return v[DV_W-1] ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/hdiv_ctrl.sv
module hdiv_ctrl #(
    parameter int LATENCY = hdiv_pkg::LAT_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic load,
    output logic step,
    output logic finish,
    output logic done
);
    localparam int STEPS = LATENCY - 1;
    localparam int CNT_W = $clog2(LATENCY);

    logic [CNT_W-1:0] cnt;

    assign load   = start && !busy;
    assign step   = busy && (cnt < CNT_W'(STEPS));
    assign finish = busy && (cnt == CNT_W'(STEPS));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (load) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (finish) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (busy) begin
                cnt  <= cnt + 1'b1;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && start && !finish) |=> (busy && !done)); // R6

endmodule

// File: rtl/hdiv_core.sv
module hdiv_core #(
    parameter int LATENCY = hdiv_pkg::LAT_DEFAULT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic                        step,
    input  logic [hdiv_pkg::DD_W-1:0]   dd_in,
    input  logic [hdiv_pkg::DV_W-1:0]   dv_in,
    output logic [((hdiv_pkg::DD_W + LATENCY - 2) / (LATENCY - 1)) * (LATENCY - 1) - 1:0] q_all,
    output logic [hdiv_pkg::DV_W-1:0]   r_mag,
    output hdiv_pkg::op_t               op
);
    import hdiv_pkg::*;

    localparam int STEPS = LATENCY - 1;
    localparam int BPS   = (DD_W + STEPS - 1) / STEPS;
    localparam int PADW  = BPS * STEPS;

    logic [DV_W-1:0] rem_q;
    logic [PADW-1:0] quo_q;
    logic [DV_W-1:0] dvs_q;
    op_t             op_q;

    // one restoring bit per stage, BPS stages per clock
    for (genvar i = 0; i < BPS; i++) begin : g_bit
        logic [DV_W-1:0] r_in;
        logic [PADW-1:0] q_in;
        logic [DV_W:0]   trial;
        logic            fit;
        logic [DV_W-1:0] r_o;
        logic [PADW-1:0] q_o;
        if (i == 0) begin : g_first
            assign r_in = rem_q;
            assign q_in = quo_q;
        end else begin : g_next
            assign r_in = g_bit[i-1].r_o;
            assign q_in = g_bit[i-1].q_o;
        end
        assign trial = {r_in, q_in[PADW-1]};
        assign fit   = trial >= {1'b0, dvs_q};
        assign r_o   = fit ? DV_W'(trial - {1'b0, dvs_q}) : trial[DV_W-1:0];
        assign q_o   = {q_in[PADW-2:0], fit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            op_q  <= '0;
        end else if (load) begin
            rem_q         <= '0;
            quo_q         <= {{(PADW-DD_W){1'b0}}, mag_dd(dd_in)};
            dvs_q         <= mag_dv(dv_in);
            op_q.dd       <= dd_in;
            op_q.neg_dd   <= dd_in[DD_W-1];
            op_q.neg_q    <= dd_in[DD_W-1] ^ dv_in[DV_W-1];
            op_q.dv_zero  <= (dv_in == '0);
        end else if (step) begin
            rem_q <= g_bit[BPS-1].r_o;
            quo_q <= g_bit[BPS-1].q_o;
        end
    end

    assign q_all = quo_q;
    assign r_mag = rem_q;
    assign op    = op_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst) (dvs_q != '0) |-> (rem_q < dvs_q)); // R4
    AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (rst) step |=> $stable(dvs_q) && $stable(op_q)); // R6

endmodule

// File: rtl/hdiv_fix.sv
module hdiv_fix #(
    parameter int PADW = 35
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        valid,
    input  logic [PADW-1:0]             q_all,
    input  logic [hdiv_pkg::DV_W-1:0]   r_mag,
    input  hdiv_pkg::op_t               op,
    output logic [hdiv_pkg::DD_W-1:0]   quo_out,
    output logic [hdiv_pkg::DD_W-1:0]   rem_out,
    output logic                        zero_out
);
    import hdiv_pkg::*;

    logic [DD_W-1:0] q_mag;
    logic [DV_W-1:0] r_signed;

    assign q_mag    = q_all[DD_W-1:0];
    assign r_signed = op.neg_dd ? (~r_mag + 1'b1) : r_mag;

    always_comb begin
        zero_out = op.dv_zero;
        if (op.dv_zero) begin
            quo_out = '1;
            rem_out = op.dd;
        end else begin
            quo_out = op.neg_q ? (~q_mag + 1'b1) : q_mag;
            rem_out = {{(DD_W-DV_W){r_signed[DV_W-1]}}, r_signed};
        end
    end

    if (PADW > DD_W) begin : g_pad
        AST_PAD_CLEAR: assert property (@(posedge clk) disable iff (rst) (valid && !op.dv_zero) |-> (q_all[PADW-1:DD_W] == '0)); // R3
    end else begin : g_nopad
        AST_VALID_KNOWN: assert property (@(posedge clk) disable iff (rst) valid |-> !$isunknown(q_all)); // R3
    end

endmodule

// File: rtl/hdiv_signed.sv
module hdiv_signed #(
    parameter int LATENCY = hdiv_pkg::LAT_DEFAULT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] dividend,
    input  logic [15:0] divisor,
    output logic        busy,
    output logic        done,
    output logic [31:0] quotient,
    output logic [31:0] remainder,
    output logic        div_zero
);
    import hdiv_pkg::*;

    localparam int STEPS = LATENCY - 1;
    localparam int BPS   = (DD_W + STEPS - 1) / STEPS;
    localparam int PADW  = BPS * STEPS;

    logic            load, step, finish;
    logic [PADW-1:0] q_all;
    logic [DV_W-1:0] r_mag;
    op_t             op;
    logic [DD_W-1:0] quo_n, rem_n;
    logic            zero_n;

    hdiv_ctrl #(.LATENCY(LATENCY)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .busy   (busy),
        .load   (load),
        .step   (step),
        .finish (finish),
        .done   (done)
    );

    hdiv_core #(.LATENCY(LATENCY)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .dd_in  (dividend),
        .dv_in  (divisor),
        .q_all  (q_all),
        .r_mag  (r_mag),
        .op     (op)
    );

    hdiv_fix #(.PADW(PADW)) u_fix (
        .clk      (clk),
        .rst      (rst),
        .valid    (finish),
        .q_all    (q_all),
        .r_mag    (r_mag),
        .op       (op),
        .quo_out  (quo_n),
        .rem_out  (rem_n),
        .zero_out (zero_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
        end else if (finish) begin
            quotient  <= quo_n;
            remainder <= rem_n;
            div_zero  <= zero_n;
        end
    end

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst) !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero))); // R8
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst) (done && div_zero) |-> (quotient == 32'hFFFF_FFFF)); // R5
    AST_REM_SIGN: assert property (@(posedge clk) disable iff (rst) (done && !div_zero) |-> (remainder[31:16] == {16{remainder[15]}})); // R4

endmodule

// File: tb/sim_hdiv_signed.sv
`timescale 1ns/1ps
module sim_hdiv_signed;

    localparam int NV = 11;
    localparam logic [31:0] V_DD [NV] = '{
        32'd100, -32'sd100, 32'd100, -32'sd100, 32'd7,
        32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
        32'd123456789, 32'h8000_0001 };
    localparam logic [15:0] V_DV [NV] = '{
        16'd7, 16'd7, -16'sd7, -16'sd7, 16'd100,
        16'd1, 16'h7FFF, 16'h8000, 16'd3,
        16'h8000, 16'd3 };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, div_zero;
    logic [31:0] quotient, remainder;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hdiv_signed u0 (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] a, input logic [15:0] b,
                                  output logic [31:0] q, output logic [31:0] r, output logic z);
        longint sa, sb, qq, rr;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (b == 16'd0) begin
            z = 1'b1; q = 32'hFFFF_FFFF; r = a;
        end else begin
            qq = sa / sb; rr = sa % sb;
            z = 1'b0; q = qq[31:0]; r = rr[31:0];
        end
    endfunction

    task automatic start_op(input logic [31:0] a, input logic [15:0] b);
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input logic [31:0] a, input logic [15:0] b, input string req);
        logic [31:0] eq, er;
        logic ez;
        model(a, b, eq, er, ez);
        chk(quotient == eq, {req, " quotient"}, quotient, eq);
        chk(remainder == er, {req, " remainder"}, remainder, er);
        chk(div_zero == ez, {req, " div_zero"}, {31'd0, div_zero}, {31'd0, ez});
    endtask

    task automatic run_div(input logic [31:0] a, input logic [15:0] b, input string req);
        int lat;
        start_op(a, b);
        chk(busy == 1'b1, "R2 busy after accept", {31'd0, busy}, 32'd1);
        wait_done(lat);
        chk(lat == 6, "R2 latency", lat, 32'd6);
        check_result(a, b, req);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic [31:0] hq, hr;
        logic hz;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0, "R1 idle flags", {30'd0, busy, done}, 32'd0);
        chk(quotient == 0 && remainder == 0 && div_zero == 0, "R1 outputs", quotient, 32'd0);
        rst = 1'b0;

        // table of vectors: R3 quotient, R4 remainder
        for (int i = 0; i < NV; i++) begin
            run_div(V_DD[i], V_DV[i], "R3 R4 vector");
        end

        // R5 zero divisor
        run_div(32'hFFFF_F00D, 16'd0, "R5 zero divisor");
        chk(div_zero == 1'b1, "R5 flag", {31'd0, div_zero}, 32'd1);

        // R8 flag clears, outputs held while pins wander
        run_div(32'd50, 16'd5, "R8 after zero");
        hq = quotient; hr = remainder; hz = div_zero;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            dividend = 32'h1234_0000 + k; divisor = 16'h0011 + 16'(k);
        end
        chk(quotient == hq && remainder == hr && div_zero == hz && !done, "R8 hold", quotient, hq);

        // R7 most negative by minus one
        run_div(32'h8000_0000, 16'hFFFF, "R7 overflow case");
        chk(quotient == 32'h8000_0000, "R7 quotient", quotient, 32'h8000_0000);

        // R6 start while busy ignored
        start_op(32'd1000, 16'd9);
        @(negedge clk);
        @(negedge clk);
        start = 1'b1; dividend = 32'd77; divisor = 16'd2;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        chk(lat == 3, "R6 timing unchanged", lat, 32'd3);
        check_result(32'd1000, 16'd9, "R6 original operands");
        lat = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done || busy) lat++;
        end
        chk(lat == 0, "R6 no extra done", lat, 32'd0);

        // R9 start in done cycle
        start_op(-32'sd5000, 16'd33);
        wait_done(lat);
        check_result(-32'sd5000, 16'd33, "R9 first");
        start = 1'b1; dividend = 32'd999; divisor = -16'sd10;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 accepted", {31'd0, busy}, 32'd1);
        wait_done(lat);
        chk(lat == 6, "R9 latency", lat, 32'd6);
        check_result(32'd999, -16'sd10, "R9 second");

        // R1 reset mid-operation
        start_op(32'd40, 16'd4);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && quotient == 0 && remainder == 0, "R1 reset clears", quotient, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule